// File: doc/BRIEF.md
# Single-Step Word Shifter with Load Register

This block moves every bit of a data word by exactly one place, in one of six
ways selected by a 3-bit mode code. It offers two zero-fill shifts, two rotates, and two
arithmetic shifts. The arithmetic shifts treat the word as a two's-complement
number. A right arithmetic shift keeps the sign. A left arithmetic shift reports when the
sign of the result no longer matches the sign of the operand. The two unused mode
codes pass the word through unchanged.

The shift itself is pure combinational logic. Its result and its overflow flag are captured in an
output register on a rising clock edge, but only while the load enable is high.
A datapath can therefore present an operand and a mode, then commit the result
when it chooses. The register holds its contents at every other edge. The word
width is a parameter with a default of 8 bits and must be at least 2.

Top module: `shift_step_reg`

## Requirements
- R1: Mode 000 (logical left) loads `{din[W-2:0], 1'b0}`; for 8 bits, 10100011 gives 01000110.
- R2: Mode 001 (logical right) loads `{1'b0, din[W-1:1]}`; for 8 bits, 10100011 gives 01010001.
- R3: Mode 010 (rotate left) loads `{din[W-2:0], din[W-1]}`; for 8 bits, 10100011 gives 01000111.
- R4: Mode 011 (rotate right) loads `{din[0], din[W-1:1]}`; for 8 bits, 10100011 gives 11010001.
- R5: Mode 101 (arithmetic right) loads `{din[W-1], din[W-1:1]}`, so the sign bit is kept; for 4 bits, 1010 gives 1101 and 0100 gives 0010.
- R6: Mode 100 (arithmetic left) loads `{din[W-2:0], 1'b0}` and sets `ovf` to `din[W-1] ^ din[W-2]`. For 4 bits, 1110 gives 1100 with no overflow, 0100 gives 1000 with overflow, and 1010 gives 0100 with overflow.
- R7: In every mode other than 100, a load writes 0 to `ovf`.
- R8: Modes 110 and 111 load `din` unchanged.
- R9: At a rising edge with `en` low and `rst` low, `dout` and `ovf` keep their values.
- R10: At a rising edge with `rst` high, `dout` and `ovf` become 0, whatever the value of `en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Load enable for the result register |
| sel | input | 3 | Shift mode code |
| din | input | WIDTH | Operand word |
| dout | output | WIDTH | Registered shifted word |
| ovf | output | 1 | Registered arithmetic-left overflow flag |

## Verification
The bench builds two copies of the block, one with WIDTH = 8 and one with WIDTH = 4. Both run through every operand value under all eight mode codes, so every edge bit, every sign transition and both pass-through codes are covered for each width. The 4-bit copy also reaches the narrow two's-complement cases, where the sign bit and its neighbour form half of the word. Directed sequences then drop the enable and raise reset with a loaded overflow flag, to show that a held value survives and that reset takes priority.

// File: rtl/shift_step_pkg.sv
package shift_step_pkg;

  typedef enum logic [2:0] {
    MODE_LSL   = 3'b000,
    MODE_LSR   = 3'b001,
    MODE_ROL   = 3'b010,
    MODE_ROR   = 3'b011,
    MODE_ASL   = 3'b100,
    MODE_ASR   = 3'b101,
    MODE_KEEP6 = 3'b110,
    MODE_KEEP7 = 3'b111
  } shift_mode_e;

  typedef enum logic [1:0] {
    DIR_HOLD  = 2'b00,
    DIR_LEFT  = 2'b01,
    DIR_RIGHT = 2'b10
  } shift_dir_e;

endpackage

// File: rtl/shift_step_decode.sv
module shift_step_decode
  import shift_step_pkg::*;
(
  input  shift_mode_e mode,
  input  logic        msb_bit,
  input  logic        lsb_bit,
  output shift_dir_e  dir,
  output logic        lsb_fill,
  output logic        msb_fill,
  output logic        asl_mode
);

  always_comb begin
    dir      = DIR_HOLD;
    lsb_fill = 1'b0;
    msb_fill = 1'b0;
    asl_mode = 1'b0;
    case (mode)
      MODE_LSL: dir = DIR_LEFT;
      MODE_LSR: dir = DIR_RIGHT;
      MODE_ROL: begin
        dir      = DIR_LEFT;
        lsb_fill = msb_bit;
      end
      MODE_ROR: begin
        dir      = DIR_RIGHT;
        msb_fill = lsb_bit;
      end
      MODE_ASL: begin
        dir      = DIR_LEFT;
        asl_mode = 1'b1;
      end
      MODE_ASR: begin
        dir      = DIR_RIGHT;
        msb_fill = msb_bit;
      end
      default: dir = DIR_HOLD;
    endcase
  end

endmodule

// File: rtl/shift_step_lane.sv
module shift_step_lane
  import shift_step_pkg::*;
(
  input  shift_dir_e dir,
  input  logic       self_bit,
  input  logic       from_lower,
  input  logic       from_upper,
  output logic       q
);

  always_comb begin
    case (dir)
      DIR_LEFT:  q = from_lower;
      DIR_RIGHT: q = from_upper;
      default:   q = self_bit;
    endcase
  end

endmodule

// File: rtl/shift_step_ovf.sv
module shift_step_ovf (
  input  logic asl_mode,
  input  logic sign_now,
  input  logic sign_next,
  output logic ovf
);

  assign ovf = asl_mode & (sign_now ^ sign_next);

endmodule

// File: rtl/shift_step_reg.sv
module shift_step_reg
  import shift_step_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       sel,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  shift_mode_e      mode;
  shift_dir_e       dir;
  logic             lsb_fill;
  logic             msb_fill;
  logic             asl_mode;
  logic [WIDTH-1:0] shifted;
  logic             ovf_c;

  assign mode = shift_mode_e'(sel);

  shift_step_decode u_decode (
    .mode     (mode),
    .msb_bit  (din[MSB]),
    .lsb_bit  (din[0]),
    .dir      (dir),
    .lsb_fill (lsb_fill),
    .msb_fill (msb_fill),
    .asl_mode (asl_mode)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    logic lower_src;
    logic upper_src;
    if (i == 0) begin : g_low_end
      assign lower_src = lsb_fill;
    end else begin : g_low_mid
      assign lower_src = din[i-1];
    end
    if (i == MSB) begin : g_high_end
      assign upper_src = msb_fill;
    end else begin : g_high_mid
      assign upper_src = din[i+1];
    end
    shift_step_lane u_lane (
      .dir        (dir),
      .self_bit   (din[i]),
      .from_lower (lower_src),
      .from_upper (upper_src),
      .q          (shifted[i])
    );
  end

  shift_step_ovf u_ovf (
    .asl_mode  (asl_mode),
    .sign_now  (din[MSB]),
    .sign_next (din[MSB-1]),
    .ovf       (ovf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      ovf  <= 1'b0;
    end else if (en) begin
      dout <= shifted;
      ovf  <= ovf_c;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (dout == '0) && !ovf); // R10

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout) && $stable(ovf)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (en && sel != 3'b100) |=> !ovf); // R7

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (en && sel[2:1] == 2'b11) |=> dout == $past(din)); // R8

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (en && sel == 3'b101) |=> dout[MSB] == $past(din[MSB])); // R5

  AST_ROTATE_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
    (en && sel[2:1] == 2'b01) |=> $countones(dout) == $countones($past(din))); // R3 R4

  AST_ASL_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (en && sel == 3'b100) |=> !dout[0]); // R6

endmodule

// File: tb/tb_shift_step_reg.sv
`timescale 1ns/1ps
module tb_shift_step_reg;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [2:0] sel = 3'b000;
  logic [7:0] din8 = '0;
  logic [3:0] din4 = '0;
  logic [7:0] dout8;
  logic [3:0] dout4;
  logic       ovf8;
  logic       ovf4;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  shift_step_reg #(.WIDTH(8)) dut (
    .clk(clk), .rst(rst), .en(en), .sel(sel), .din(din8), .dout(dout8), .ovf(ovf8)
  );

  shift_step_reg #(.WIDTH(4)) dut_narrow (
    .clk(clk), .rst(rst), .en(en), .sel(sel), .din(din4), .dout(dout4), .ovf(ovf4)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_word(int w, int v, int s);
    int m = 1 << w;
    int h = m / 2;
    case (s)
      0, 4: return (v * 2) % m;
      1:    return v / 2;
      2:    return (v * 2) % m + v / h;
      3:    return v / 2 + (v % 2) * h;
      5:    return v / 2 + ((v >= h) ? h : 0);
      default: return v;
    endcase
  endfunction

  function automatic int model_ovf(int w, int v, int s);
    int m = 1 << w;
    int h = m / 2;
    if (s != 4) return 0;
    return (((v * 2) % m >= h) != (v >= h)) ? 1 : 0;
  endfunction

  function automatic string word_req(int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R6";
      5: return "R5";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "reset dout8", dout8, 0);
    check("R10", "reset ovf8", ovf8, 0);
    check("R10", "reset dout4", dout4, 0);
    rst = 1'b0;

    for (int v = 0; v < 256; v++) begin
      for (int s = 0; s < 8; s++) begin
        din8 = v[7:0];
        din4 = v[3:0];
        sel  = s[2:0];
        en   = 1'b1;
        @(negedge clk);
        check(word_req(s), "word w8", dout8, model_word(8, v, s));
        check(word_req(s), "word w4", dout4, model_word(4, v % 16, s));
        check((s == 4) ? "R6" : "R7", "ovf w8", ovf8, model_ovf(8, v, s));
        check((s == 4) ? "R6" : "R7", "ovf w4", ovf4, model_ovf(4, v % 16, s));
      end
    end

    // R9: rotate-left result must survive disabled edges
    din8 = 8'hA3; sel = 3'b010; en = 1'b1;
    @(negedge clk);
    check("R3", "rotate 10100011", dout8, 8'h47);
    en = 1'b0; din8 = 8'h00; sel = 3'b001;
    repeat (3) @(negedge clk);
    check("R9", "held word", dout8, 8'h47);
    check("R9", "held ovf low", ovf8, 0);

    // R9: a set overflow flag must also be held
    din8 = 8'h40; din4 = 4'b1010; sel = 3'b100; en = 1'b1;
    @(negedge clk);
    check("R6", "asl 0x40 ovf", ovf8, 1);
    check("R6", "asl 1010 word", dout4, 4'b0100);
    check("R6", "asl 1010 ovf", ovf4, 1);
    en = 1'b0; din8 = 8'h00; din4 = 4'h0; sel = 3'b000;
    repeat (2) @(negedge clk);
    check("R9", "held ovf high", ovf8, 1);
    check("R9", "held word 0x80", dout8, 8'h80);
    check("R9", "held narrow word", dout4, 4'b0100);

    // R10: reset wins over an active load
    din8 = 8'hFF; din4 = 4'b0100; sel = 3'b100; en = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R10", "reset over load dout8", dout8, 0);
    check("R10", "reset over load ovf8", ovf8, 0);
    check("R10", "reset over load ovf4", ovf4, 0);
    rst = 1'b0; en = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule